// File: doc/BRIEF.md
# Program Memory Partition Guard

This block sits between a processor core and a 64 KB program flash, and it splits the flash into two partitions. The lower partition is protected and the upper partition is open. The split point comes from an 8-bit limit register. Software writes that register through the special-function-register port, and it accepts only one write after each reset. The 16-bit boundary is the register value placed in the high byte with a zero low byte, so the boundary always falls on a 256-byte step.

Every code-space data request (read, write or erase) arrives with the program counter of the instruction that issued it. A request is blocked when that program counter lies in the upper partition and the target lies in the lower partition. A blocked write or erase never reaches the flash, and a one-cycle debug strobe reports it. A blocked read still goes to the flash, but the data returned to the core is forced to 0x00. That override is pipelined to match the flash read latency.

Top module: `flash_part_guard`

## Requirements
- R1: The boundary is {limit, 8'h00}. A target address is in the lower partition when it is strictly below the boundary. A program counter is in the upper partition when it is at or above the boundary.
- R2: After reset the limit is 0x00, so the boundary is 0x0000 and no request is blocked.
- R3: After a reset, the first write with sfr_addr equal to 0xB7 loads sfr_wdata into the limit. Every later write is ignored until the next reset. Writes to any other address never change the limit.
- R4: sfr_rdata shows the current limit whenever sfr_addr is 0xB7, and shows 0x00 for any other address.
- R5: A read (req_op 0) from an upper-partition program counter to a lower-partition target is still forwarded to the flash. The rsp_rdata value returned RD_LAT cycles later is 0x00.
- R6: A read that is not blocked returns fl_rdata unchanged on rsp_rdata, in particular any read issued from lower-partition code.
- R7: A write (req_op 1) or erase (req_op 2 or 3) from an upper-partition program counter to a lower-partition target holds fl_req low in that cycle.
- R8: viol is high for exactly the cycle after a blocked write or erase, and stays low after blocked reads and after allowed requests.
- R9: An allowed request drives fl_req high in the same cycle, with fl_op, fl_addr and fl_wdata equal to the request fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sfr_wr | input | 1 | Special-function-register write strobe |
| sfr_addr | input | 8 | Special-function-register address |
| sfr_wdata | input | 8 | Special-function-register write data |
| sfr_rdata | output | 8 | Limit readback |
| req_valid | input | 1 | Code-space request valid |
| req_op | input | 2 | 0 read, 1 write, 2/3 erase |
| req_pc | input | 16 | Program counter of the requester |
| req_addr | input | 16 | Target address |
| req_wdata | input | 8 | Write data |
| fl_req | output | 1 | Request to the flash |
| fl_op | output | 2 | Operation to the flash |
| fl_addr | output | 16 | Address to the flash |
| fl_wdata | output | 8 | Write data to the flash |
| fl_rdata | input | 8 | Flash read data, RD_LAT cycles after the read |
| rsp_rdata | output | 8 | Read data to the core |
| viol | output | 1 | Blocked write/erase strobe |

## Verification
The forwarding outputs (fl_req, fl_op, fl_addr, fl_wdata) and sfr_rdata are combinational. The bench checks them in the same cycle as the stimulus, 1 ns before the next rising edge. The viol strobe and the read data on rsp_rdata are due one edge later with the default RD_LAT of 1. The bench checks both 1 ns after that edge, before the next stimulus is applied. A limit write takes effect at the edge where it is sampled, so a request in the same cycle still sees the old boundary. The bench therefore waits one full cycle after each limit write before it issues a request.

// File: rtl/flash_part_guard.sv
module flash_part_guard #(
  parameter int ADDR_W = 16,
  parameter int LIM_W = 8,
  parameter int DATA_W = 8,
  parameter int RD_LAT = 1,
  parameter logic [7:0] LIMIT_SFR = 8'hB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_wr,
  input  logic [7:0]        sfr_addr,
  input  logic [LIM_W-1:0]  sfr_wdata,
  output logic [LIM_W-1:0]  sfr_rdata,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              fl_req,
  output logic [1:0]        fl_op,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_wdata,
  input  logic [DATA_W-1:0] fl_rdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              viol
);
  localparam int LOW_W = ADDR_W - LIM_W;

  logic [LIM_W-1:0]  limit_q;
  logic              written_q;
  logic [RD_LAT-1:0] blank_q;
  logic              viol_q;

  wire [ADDR_W-1:0] bound   = {limit_q, {LOW_W{1'b0}}};
  wire              is_rd   = (req_op == 2'd0);
  wire              blocked = req_valid && (req_pc >= bound) && (req_addr < bound);
  wire              lim_we  = sfr_wr && (sfr_addr == LIMIT_SFR) && !written_q;

  assign sfr_rdata = (sfr_addr == LIMIT_SFR) ? limit_q : '0;
  assign fl_req    = req_valid && !(blocked && !is_rd);
  assign fl_op     = req_op;
  assign fl_addr   = req_addr;
  assign fl_wdata  = req_wdata;
  assign rsp_rdata = blank_q[RD_LAT-1] ? '0 : fl_rdata;
  assign viol      = viol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q   <= '0;
      written_q <= 1'b0;
    end else if (lim_we) begin
      limit_q   <= sfr_wdata;
      written_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q <= '0;
      viol_q  <= 1'b0;
    end else begin
      blank_q[0] <= blocked && is_rd;
      for (int i = 1; i < RD_LAT; i++) blank_q[i] <= blank_q[i-1];
      viol_q <= blocked && !is_rd;
    end
  end

  assert_reset_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !written_q |-> limit_q == '0);
  assert_write_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    written_q |=> $stable(limit_q));
  assert_drop_modify_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !is_rd && req_pc >= bound && req_addr < bound) |-> !fl_req);
  assert_strobe_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> $past(req_valid && req_op != 2'd0 && !fl_req));
  assert_zero_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blank_q[RD_LAT-1] |-> rsp_rdata == '0);
  assert_pass_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_q[RD_LAT-1] |-> rsp_rdata == fl_rdata);
  assert_forward_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req |-> (req_valid && fl_addr == req_addr && fl_op == req_op));
endmodule

// File: tb/sim_flash_part_guard.sv
module sim_flash_part_guard;
  logic clk = 0, rst_n = 0;
  logic sfr_wr = 0;
  logic [7:0] sfr_addr = 0, sfr_wdata = 0, sfr_rdata;
  logic req_valid = 0;
  logic [1:0] req_op = 0;
  logic [15:0] req_pc = 0, req_addr = 0;
  logic [7:0] req_wdata = 0;
  logic fl_req, viol;
  logic [1:0] fl_op;
  logic [15:0] fl_addr;
  logic [7:0] fl_wdata, fl_rdata, rsp_rdata;
  int checks = 0, errors = 0;
  logic [7:0] lim_m;

  always #5 clk = ~clk;

  flash_part_guard u0 (.clk, .rst_n, .sfr_wr, .sfr_addr, .sfr_wdata, .sfr_rdata,
    .req_valid, .req_op, .req_pc, .req_addr, .req_wdata, .fl_req, .fl_op,
    .fl_addr, .fl_wdata, .fl_rdata, .rsp_rdata, .viol);

  function automatic logic [7:0] mem_val(input logic [15:0] a);
    return {a[7:1] ^ a[15:9], 1'b1};
  endfunction

  function automatic logic is_blocked(input logic [7:0] lim, input logic [15:0] pc,
                                      input logic [15:0] ad);
    return (pc >= {lim, 8'h00}) && (ad < {lim, 8'h00});
  endfunction

  always_ff @(posedge clk) if (fl_req && fl_op == 2'd0) fl_rdata <= mem_val(fl_addr);

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; sfr_wr = 0; req_valid = 0;
    @(negedge clk); rst_n = 1; lim_m = 0;
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); sfr_wr = 1; sfr_addr = a; sfr_wdata = d;
    if (a == 8'hB7 && lim_m == 8'h00 && !wrote) begin lim_m = d; wrote = 1; end
    @(negedge clk); sfr_wr = 0;
  endtask

  logic wrote = 0;

  task automatic req(input logic [1:0] op, input logic [15:0] pc, input logic [15:0] ad,
                     input logic [7:0] wd);
    logic b;
    b = is_blocked(lim_m, pc, ad);
    @(negedge clk);
    req_valid = 1; req_op = op; req_pc = pc; req_addr = ad; req_wdata = wd;
    #4;
    if (op != 0 && b) check(fl_req == 0, "R7 dropped", fl_req, 0);
    else begin
      check(fl_req == 1, "R9 forward", fl_req, 1);
      check(fl_addr == ad && fl_op == op && fl_wdata == wd, "R9 fields", fl_addr, ad);
    end
    @(posedge clk); #1;
    req_valid = 0;
    check(viol == (op != 0 && b), "R8 strobe", viol, op != 0 && b);
    if (op == 0) begin
      if (b) check(rsp_rdata == 0, "R5 zeroed read", rsp_rdata, 0);
      else check(rsp_rdata == mem_val(ad), "R6 passed read", rsp_rdata, mem_val(ad));
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    do_reset(); wrote = 0;
    sfr_addr = 8'hB7; #1;
    check(sfr_rdata == 0, "R2 reset limit", sfr_rdata, 0);
    check(viol == 0, "R8 reset strobe", viol, 0);
    req(2'd0, 16'hFFFF, 16'h0000, 0);   // R2 nothing blocked
    req(2'd1, 16'hFFFF, 16'h0000, 8'h3C);
    sfr_write(8'hB6, 8'h33);            // R3 other address ignored
    sfr_addr = 8'hB7; #1;
    check(sfr_rdata == 0, "R3 other addr", sfr_rdata, 0);
    sfr_write(8'hB7, 8'h40);
    sfr_addr = 8'hB7; #1;
    check(sfr_rdata == 8'h40, "R3 first write / R4 readback", sfr_rdata, 8'h40);
    sfr_addr = 8'hB6; #1;
    check(sfr_rdata == 0, "R4 other addr reads 0", sfr_rdata, 0);
    sfr_write(8'hB7, 8'h80);
    sfr_addr = 8'hB7; #1;
    check(sfr_rdata == 8'h40, "R3 second write ignored", sfr_rdata, 8'h40);
    req(2'd0, 16'h4000, 16'h3FFF, 0);   // R1 R5 boundary edges
    req(2'd0, 16'h4000, 16'h4000, 0);   // R1 target at boundary allowed
    req(2'd0, 16'h3FFF, 16'h0000, 0);   // R6 lower code reads anything
    req(2'd1, 16'h8000, 16'h0100, 8'hAA);
    req(2'd2, 16'hFFFF, 16'h3F00, 0);
    req(2'd3, 16'h4000, 16'h0000, 0);
    req(2'd1, 16'h1000, 16'h0100, 8'h55);
    do_reset(); wrote = 0;
    sfr_addr = 8'hB7; #1;
    check(sfr_rdata == 0, "R3 reset clears limit", sfr_rdata, 0);
    sfr_write(8'hB7, 8'h12);
    sfr_addr = 8'hB7; #1;
    check(sfr_rdata == 8'h12, "R3 write after reset", sfr_rdata, 8'h12);
    for (int n = 0; n < 600; n++) begin
      if (n % 100 == 99) begin
        do_reset(); wrote = 0;
        sfr_write(8'hB7, 8'($urandom));
      end
      req(2'($urandom), 16'($urandom), 16'($urandom), 8'($urandom));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule